// File: doc/BRIEF.md
# Power-Line Elapsed Time Counter

This block keeps a 24-bit running count of mains cycles. A once-per-cycle tick from the power line comes in on an asynchronous pin. It passes through a short synchroniser, and each rising edge adds one to the count. Software sets the interval by writing a start value of 2^24 minus the number of ticks it wants to wait. When an increment carries the count from all ones to zero, the block raises a sticky interrupt request.

The request stays pending until the interrupt controller acknowledges it. A mask input gates the request at the output. The count keeps advancing whether or not the request is masked, and an overflow that occurs while masked is still held pending. At 60 Hz a zero start value takes about 77 hours to wrap. At 50 Hz it takes about 93 hours.

Top module: `elapsed_timer`

## Requirements
- R1: While rst_n is low, count_o is 0 and irq_req_o is 0.
- R2: Each rising edge on tick_in adds exactly one to count_o. A tick held high for many cycles still counts once. The new value appears at the third rising clock edge after tick_in is first high at a clock edge, counting that edge as the first.
- R3: When load_en is high at a clock edge, count_o takes load_val at that edge. A load wins over an increment due at the same edge, and that increment is lost.
- R4: An increment from 24'hFFFFFF gives 24'h000000.
- R5: The wrap of R4 sets an internal pending flag at the same edge. irq_req_o is high exactly when that flag is set and irq_enable is 1.
- R6: With irq_enable at 0, ticks still advance count_o, and a wrap still sets the pending flag. Raising irq_enable later makes irq_req_o high.
- R7: The pending flag stays set until irq_ack is high at a clock edge. Several wraps before the acknowledge leave a single request, which one acknowledge clears.
- R8: If a wrap and irq_ack occur at the same edge, the pending flag stays set.
- R9: A start value of 2^24 - N raises the request on the N-th tick and not before. For N = 3600 the start value is 24'hFFF1F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Mains-cycle tick, asynchronous |
| load_en | input | 1 | Write load_val into the count |
| load_val | input | 24 | Start value written by software |
| irq_enable | input | 1 | Timer interrupt mask, 1 lets the request out |
| irq_ack | input | 1 | Acknowledge from the interrupt controller |
| count_o | output | 24 | Current elapsed count |
| irq_req_o | output | 1 | Timer interrupt request |

## Verification
A tick reaches the count three clock edges after tick_in is first sampled high: two synchroniser flops, then the count register. The bench drives inputs on falling edges. It checks both the old value after the second edge and the new value after the third. A load, an acknowledge and the pending flag each take one edge. irq_req_o follows irq_enable within the same cycle, so those checks sample at the next falling edge. The same-edge cases, load against tick and wrap against acknowledge, are set up by raising load_en or irq_ack in the cycle after the second synchroniser edge.

// File: rtl/et_pkg.sv
package et_pkg;
  localparam int unsigned ET_CNT_W       = 24;
  localparam int unsigned ET_SYNC_STAGES = 2;
endpackage

// File: rtl/et_tick_sync.sv
module et_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_pulse_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = tick_in;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], tick_in};
    end
  endgenerate

  always_comb prev_d = sync_q[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb tick_pulse_o = sync_q[LAST] & ~prev_q;

  // R2: one count per edge, so the pulse never lasts two cycles
  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pulse_o |=> !tick_pulse_o);
endmodule

// File: rtl/et_counter.sv
module et_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             do_inc;

  always_comb begin
    do_inc = inc_i & ~load_i;
    cnt_en = load_i | inc_i;
    cnt_d  = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (inc_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_comb begin
    cnt_o  = cnt_q;
    wrap_o = do_inc & (cnt_q == ALL_ONES);
  end

  assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
  assert_add_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc_i && !load_i) |=> $stable(cnt_q));
  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> cnt_q == '0);
endmodule

// File: rtl/et_irq.sv
module et_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic ack_i,
  input  logic enable_i,
  output logic req_o
);
  logic pend_q, pend_d;

  always_comb pend_d = wrap_i | (pend_q & ~ack_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_comb req_o = pend_q & enable_i;

  assert_wrap_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> pend_q);
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack_i) |=> pend_q);
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !wrap_i) |=> !pend_q);
  assert_wrap_beats_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && wrap_i) |=> pend_q);
endmodule

// File: rtl/elapsed_timer.sv
module elapsed_timer #(
  parameter int unsigned CNT_W       = et_pkg::ET_CNT_W,
  parameter int unsigned SYNC_STAGES = et_pkg::ET_SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_in,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_enable,
  input  logic             irq_ack,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_req_o
);
  logic tick_pulse;
  logic wrap;

  et_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_in      (tick_in),
    .tick_pulse_o (tick_pulse)
  );

  et_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_i      (tick_pulse),
    .load_i     (load_en),
    .load_val_i (load_val),
    .cnt_o      (count_o),
    .wrap_o     (wrap)
  );

  et_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrap_i   (wrap),
    .ack_i    (irq_ack),
    .enable_i (irq_enable),
    .req_o    (irq_req_o)
  );

  assert_mask_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> irq_enable);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (count_o == '0 && !irq_req_o));
endmodule

// File: tb/elapsed_timer_bench.sv
module elapsed_timer_bench;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick_in, load_en, irq_enable, irq_ack;
  logic [W-1:0] load_val;
  logic [W-1:0] count_o;
  logic         irq_req_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  elapsed_timer u_elapsed_timer (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .load_en(load_en),
    .load_val(load_val), .irq_enable(irq_enable), .irq_ack(irq_ack),
    .count_o(count_o), .irq_req_o(irq_req_o)
  );

  typedef struct packed {
    logic [W-1:0] preset;
    logic [7:0]   ticks;
    logic [W-1:0] exp_cnt;
    logic         exp_irq;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{24'h000000, 8'd5,  24'h000005, 1'b0},
    '{24'hFFFFFE, 8'd1,  24'hFFFFFF, 1'b0},
    '{24'hFFFFFE, 8'd2,  24'h000000, 1'b1},
    '{24'hFFFFFD, 8'd5,  24'h000002, 1'b1},
    '{24'h123456, 8'd16, 24'h123466, 1'b0},
    '{24'hFFFFF0, 8'd16, 24'h000000, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick_once();
    @(negedge clk) tick_in = 1'b1;
    repeat (3) @(negedge clk);
    tick_in = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic load(input logic [W-1:0] v);
    @(negedge clk) begin load_en = 1'b1; load_val = v; end
    @(negedge clk) load_en = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick_in = 1'b0; load_en = 1'b0; load_val = '0;
    irq_enable = 1'b1; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset count", 32'(count_o), 0);
    check("R1 reset irq", 32'(irq_req_o), 0);
    rst_n = 1'b1;

    // table walk: R2 R4 R5 R9 under several start values
    for (int i = 0; i < NV; i++) begin
      ack_pulse();
      load(VECS[i].preset);
      for (int t = 0; t < int'(VECS[i].ticks); t++) tick_once();
      check("R2/R4 table count", 32'(count_o), 32'(VECS[i].exp_cnt));
      check("R5 table irq", 32'(irq_req_o), 32'(VECS[i].exp_irq));
    end

    // R2 timing and a long high level counts once
    ack_pulse();
    load(24'h000010);
    @(negedge clk) tick_in = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 not yet after two edges", 32'(count_o), 32'h10);
    @(negedge clk);
    check("R2 due at third edge", 32'(count_o), 32'h11);
    repeat (20) @(negedge clk);
    check("R2 held high counts once", 32'(count_o), 32'h11);
    tick_in = 1'b0;
    repeat (4) @(negedge clk);

    // R3 load and increment at the same edge
    @(negedge clk) tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk) begin load_en = 1'b1; load_val = 24'hABCDEF; end
    @(negedge clk) load_en = 1'b0;
    check("R3 load beats tick", 32'(count_o), 32'hABCDEF);
    repeat (5) @(negedge clk);
    check("R3 tick dropped", 32'(count_o), 32'hABCDEF);
    tick_in = 1'b0;
    repeat (3) @(negedge clk);

    // R6 masked overflow keeps counting and stays pending
    irq_enable = 1'b0;
    load(24'hFFFFFF);
    tick_once();
    check("R6 masked wrap count", 32'(count_o), 0);
    check("R6 masked no request", 32'(irq_req_o), 0);
    tick_once(); tick_once();
    check("R6 counting while masked", 32'(count_o), 2);
    @(negedge clk) irq_enable = 1'b1;
    @(negedge clk);
    check("R6 pending shows on unmask", 32'(irq_req_o), 1);

    // R7 second wrap before ack, one ack clears
    load(24'hFFFFFF);
    tick_once();
    check("R7 still requesting", 32'(irq_req_o), 1);
    ack_pulse();
    check("R7 single ack clears", 32'(irq_req_o), 0);
    repeat (5) @(negedge clk);
    check("R7 stays clear", 32'(irq_req_o), 0);

    // R8 wrap and ack at the same edge
    load(24'hFFFFFF);
    @(negedge clk) tick_in = 1'b1;
    @(negedge clk);
    @(negedge clk) irq_ack = 1'b1;
    @(negedge clk) irq_ack = 1'b0;
    check("R8 wrap beats ack", 32'(irq_req_o), 1);
    check("R4 wrap count", 32'(count_o), 0);
    tick_in = 1'b0;
    ack_pulse();
    check("R8 later ack clears", 32'(irq_req_o), 0);

    // R9 3600-tick interval
    load(24'hFFF1F0);
    for (int t = 0; t < 3599; t++) tick_once();
    check("R9 no request before Nth tick", 32'(irq_req_o), 0);
    check("R9 count before Nth tick", 32'(count_o), 32'hFFFFFF);
    tick_once();
    check("R9 request on Nth tick", 32'(irq_req_o), 1);

    // R1 reset mid-run
    load(24'h000777);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears count", 32'(count_o), 0);
    check("R1 reset clears irq", 32'(irq_req_o), 0);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule